// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two stack pointer pairs for a small CPU core, one used by ordinary code and one used by system and interrupt code. Each pair consists of an 8-bit bank register and a 16-bit pointer. Concatenated, they form a 24-bit stack address: the bank is the upper byte and the pointer is the lower 16 bits. A one-bit stack-select flag decides which pair is active. The flag is 1 (system pair) after reset and whenever an interrupt is accepted. Software may also write the flag directly.

Stack operations arrive as requests on a valid/ready stream, each marked as a word push or a word pop. The stack grows toward lower addresses. A push first lowers the selected pointer by two and then issues the new address. A pop issues the current address and then raises the pointer by two. Pointer arithmetic wraps within 16 bits and never touches the bank. The resulting addresses leave on a second valid/ready stream through a one-entry register. Back-pressure rules: a request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or its content is being taken in the same cycle (`addr_valid` low or `addr_ready` high). An address shown with `addr_valid` high stays unchanged until `addr_ready` is seen high. A small register port gives software read and write access to all four registers.

Top module: `bank_stack_unit`

## Requirements
- R1: After reset the stack flag is 1, all four registers read 0 and `addr_valid` is 0.
- R2: The flag selects the active pair: 0 selects the user bank and user pointer, 1 selects the system bank and system pointer. Every issued address is {bank, 16-bit low part}.
- R3: An accepted push lowers the selected pointer by 2. The issued address carries the lowered value.
- R4: An accepted pop issues the pointer's current value as the address. The pointer then rises by 2.
- R5: Pointer arithmetic wraps modulo 2^16 (a push at 0x0000 gives 0xFFFE, a pop at 0xFFFE gives 0x0000). The bank register is never altered by push or pop.
- R6: A push or pop changes only the selected pointer. The other pointer and both banks keep their values.
- R7: Register port selector codes are: 0 = user pointer, 1 = user bank, 2 = system pointer, 3 = system bank. A bank write takes bits [7:0] of the write data. A bank read returns the bank zero-extended to 16 bits. Writes take effect at the clock edge. The read data follows `reg_rd_sel` combinationally.
- R8: A software flag write sets the flag to `flag_wr_val`. A request accepted in the same cycle already uses the written value.
- R9: `int_accept` sets the flag to 1. It overrides a software flag write in the same cycle, and a request accepted in that cycle uses the system pair.
- R10: When a register write and an accepted request target the same pointer in the same cycle, the pointer takes the written value. The issued address is computed from the pointer value before the write.
- R11: An accepted request's address appears on `addr_data` with `addr_valid` high on the following cycle. While `addr_valid` is high and `addr_ready` is low, `addr_data` and `addr_valid` hold and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_accept | input | 1 | One-cycle pulse: an interrupt has been accepted |
| flag_wr_en | input | 1 | Software write of the stack flag |
| flag_wr_val | input | 1 | Value for the flag write |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_wr_sel | input | 2 | Register selector for writes |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_sel | input | 2 | Register selector for reads |
| reg_rd_data | output | 16 | Register read data |
| req_valid | input | 1 | Stack request valid |
| req_ready | output | 1 | Stack request ready |
| req_pop | input | 1 | 1 = word pop, 0 = word push |
| addr_valid | output | 1 | Stack address valid |
| addr_ready | input | 1 | Stack address accepted by consumer |
| addr_data | output | 24 | Stack address {bank, pointer} |
| stack_flag | output | 1 | Current stack-select flag |

## Verification
The hardest situations to reach are same-cycle collisions. Examples are an interrupt pulse, a software flag write and a push all landing on one edge, or a pointer write meeting a push to that same pointer. Each gives a different result depending on which effect wins. The stimulus drives all colliding inputs together in a single cycle, and the bench's reference model applies the stated priorities to predict both the issued address and the register contents read back afterwards. A stalled output is produced by holding `addr_ready` low while a second request is offered. This shows that the address holds and that the request is refused rather than lost.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    SEL_USR_PTR  = 2'd0,
    SEL_USR_BANK = 2'd1,
    SEL_SYS_PTR  = 2'd2,
    SEL_SYS_BANK = 2'd3
  } stk_reg_sel_e;

  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned PAIR_USR  = 0;
  localparam int unsigned PAIR_SYS  = 1;
endpackage

// File: rtl/stk_flag_ctrl.sv
module stk_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic int_accept,
  input  logic sw_wr_en,
  input  logic sw_wr_val,
  output logic flag_q,
  output logic flag_eff
);
  // interrupt acceptance outranks a software write; both act in this cycle
  always_comb begin
    if (int_accept)    flag_eff = 1'b1;
    else if (sw_wr_en) flag_eff = sw_wr_val;
    else               flag_eff = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_eff;
  end

  assert_reset_sys_R1: assert property (@(posedge clk) !rst_n |=> flag_q);
  assert_int_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_accept |=> flag_q);
  assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !int_accept) |=> (flag_q == $past(sw_wr_val)));
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && !int_accept) |=> $stable(flag_q));
endmodule

// File: rtl/stk_pair.sv
module stk_pair #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic              op_pop,
  input  logic              ptr_wr_en,
  input  logic              bank_wr_en,
  input  logic [PTR_W-1:0]  wr_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [PTR_W-1:0]  op_lo
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  logic [PTR_W-1:0] ptr_dec, ptr_inc, ptr_d;

  assign ptr_dec = ptr_q - STEP_V;
  assign ptr_inc = ptr_q + STEP_V;
  // push issues the lowered value, pop issues the value before the raise
  assign op_lo   = op_pop ? ptr_q : ptr_dec;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_wr_en)  ptr_d = wr_data;
    else if (op_en) ptr_d = op_pop ? ptr_inc : ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      bank_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (bank_wr_en) bank_q <= wr_data[BANK_W-1:0];
    end
  end

  assert_push_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !op_pop && !ptr_wr_en) |=> (ptr_q == PTR_W'($past(ptr_q) - STEP_V)));
  assert_pop_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_pop && !ptr_wr_en) |=> (ptr_q == PTR_W'($past(ptr_q) + STEP_V)));
  assert_bank_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr_en |=> $stable(bank_q));
  assert_idle_ptr_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en && !ptr_wr_en) |=> $stable(ptr_q));
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> (ptr_q == $past(wr_data)));
endmodule

// File: rtl/stk_addr_stage.sv
module stk_addr_stage #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= in_addr;
    end
  end

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
  assert_accept_shows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr)));
endmodule

// File: rtl/bank_stack_unit.sv
module bank_stack_unit #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned STEP   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      int_accept,
  input  logic                      flag_wr_en,
  input  logic                      flag_wr_val,
  input  logic                      reg_wr_en,
  input  logic [1:0]                reg_wr_sel,
  input  logic [PTR_W-1:0]          reg_wr_data,
  input  logic [1:0]                reg_rd_sel,
  output logic [PTR_W-1:0]          reg_rd_data,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_pop,
  output logic                      addr_valid,
  input  logic                      addr_ready,
  output logic [PTR_W+BANK_W-1:0]   addr_data,
  output logic                      stack_flag
);
  import stk_pkg::*;

  localparam int unsigned ADDR_W = PTR_W + BANK_W;

  logic flag_q, flag_eff, fire;
  logic [NUM_PAIRS-1:0][PTR_W-1:0]  ptr_arr, lo_arr;
  logic [NUM_PAIRS-1:0][BANK_W-1:0] bank_arr;
  logic [ADDR_W-1:0] op_addr;
  stk_reg_sel_e wr_sel, rd_sel;

  assign wr_sel     = stk_reg_sel_e'(reg_wr_sel);
  assign rd_sel     = stk_reg_sel_e'(reg_rd_sel);
  assign fire       = req_valid && req_ready;
  assign stack_flag = flag_q;

  stk_flag_ctrl u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_accept(int_accept),
    .sw_wr_en  (flag_wr_en),
    .sw_wr_val (flag_wr_val),
    .flag_q    (flag_q),
    .flag_eff  (flag_eff)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam stk_reg_sel_e PTR_SEL  = (g == PAIR_SYS) ? SEL_SYS_PTR  : SEL_USR_PTR;
    localparam stk_reg_sel_e BANK_SEL = (g == PAIR_SYS) ? SEL_SYS_BANK : SEL_USR_BANK;
    logic sel_me;
    assign sel_me = (flag_eff == 1'(g));

    stk_pair #(.PTR_W(PTR_W), .BANK_W(BANK_W), .STEP(STEP)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_en     (fire && sel_me),
      .op_pop    (req_pop),
      .ptr_wr_en (reg_wr_en && (wr_sel == PTR_SEL)),
      .bank_wr_en(reg_wr_en && (wr_sel == BANK_SEL)),
      .wr_data   (reg_wr_data),
      .ptr_q     (ptr_arr[g]),
      .bank_q    (bank_arr[g]),
      .op_lo     (lo_arr[g])
    );
  end

  assign op_addr = {bank_arr[flag_eff], lo_arr[flag_eff]};

  stk_addr_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_addr  (op_addr),
    .in_ready (req_ready),
    .out_valid(addr_valid),
    .out_ready(addr_ready),
    .out_addr (addr_data)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_USR_PTR:  reg_rd_data = ptr_arr[PAIR_USR];
      SEL_USR_BANK: reg_rd_data = {{(PTR_W-BANK_W){1'b0}}, bank_arr[PAIR_USR]};
      SEL_SYS_PTR:  reg_rd_data = ptr_arr[PAIR_SYS];
      default:      reg_rd_data = {{(PTR_W-BANK_W){1'b0}}, bank_arr[PAIR_SYS]};
    endcase
  end

  // the pair not selected this cycle must not move unless software writes it
  assert_other_ptr_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && flag_eff && !(reg_wr_en && wr_sel == SEL_USR_PTR))
      |=> $stable(ptr_arr[PAIR_USR]));
  assert_int_uses_sys_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int_accept) |=> (addr_data[ADDR_W-1:PTR_W] == $past(bank_arr[PAIR_SYS])));
endmodule

// File: tb/tb_bank_stack_unit.sv
`timescale 1ns/100ps
module tb_bank_stack_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_accept = 0, flag_wr_en = 0, flag_wr_val = 0, reg_wr_en = 0;
  logic [1:0] reg_wr_sel = 0, reg_rd_sel = 0;
  logic [15:0] reg_wr_data = 0, reg_rd_data;
  logic req_valid = 0, req_ready, req_pop = 0, addr_valid, addr_ready = 1, stack_flag;
  logic [23:0] addr_data;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] m_ptr [2];
  logic [7:0]  m_bank [2];
  logic        m_flag;
  logic [23:0] exp_q [$];
  string       tag_q [$];
  string       cur_tag = "R2";

  always #2.5 clk = ~clk;

  bank_stack_unit dut (
    .clk(clk), .rst_n(rst_n), .int_accept(int_accept), .flag_wr_en(flag_wr_en),
    .flag_wr_val(flag_wr_val), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_pop(req_pop),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
    .stack_flag(stack_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare every transferred address with the scoreboard
  initial forever begin
    @(negedge clk);
    #2;
    if (addr_valid && addr_ready) begin
      if (exp_q.size() == 0) chk("R11 unexpected address", addr_data, 32'hdead);
      else chk({tag_q.pop_front(), " address"}, addr_data, exp_q.pop_front());
    end
  end

  // driver: one cycle from a negedge; model applies the stated priorities
  task automatic tick();
    logic eff;
    logic [23:0] a;
    int s;
    #2;
    eff = int_accept ? 1'b1 : (flag_wr_en ? flag_wr_val : m_flag);
    if (req_valid && req_ready) begin
      s = eff ? 1 : 0;
      if (req_pop) begin
        a = {m_bank[s], m_ptr[s]};
        m_ptr[s] = m_ptr[s] + 16'd2;
      end else begin
        m_ptr[s] = m_ptr[s] - 16'd2;
        a = {m_bank[s], m_ptr[s]};
      end
      exp_q.push_back(a);
      tag_q.push_back(cur_tag);
    end
    if (reg_wr_en) begin
      case (reg_wr_sel)
        2'd0: m_ptr[0]  = reg_wr_data;
        2'd1: m_bank[0] = reg_wr_data[7:0];
        2'd2: m_ptr[1]  = reg_wr_data;
        default: m_bank[1] = reg_wr_data[7:0];
      endcase
    end
    m_flag = eff;
    @(negedge clk);
    req_valid = 0; int_accept = 0; flag_wr_en = 0; reg_wr_en = 0;
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [15:0] d);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    tick();
  endtask

  task automatic op(logic pop, string tag);
    cur_tag = tag; req_valid = 1; req_pop = pop;
    tick();
  endtask

  task automatic check_regs(string tag);
    logic [15:0] e;
    for (int i = 0; i < 4; i++) begin
      reg_rd_sel = 2'(i);
      #0.3;
      case (i)
        0: e = m_ptr[0];
        1: e = {8'h00, m_bank[0]};
        2: e = m_ptr[1];
        default: e = {8'h00, m_bank[1]};
      endcase
      chk({tag, " register read"}, {16'h0, reg_rd_data}, {16'h0, e});
    end
    chk({tag, " flag"}, {31'h0, stack_flag}, {31'h0, m_flag});
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ptr[0] = 0; m_ptr[1] = 0; m_bank[0] = 0; m_bank[1] = 0; m_flag = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_regs("R1");
    chk("R1 addr_valid", {31'h0, addr_valid}, 0);

    // R7: register port writes, bank takes low byte
    wr_reg(2'd0, 16'h1000);
    wr_reg(2'd1, 16'h0012);
    wr_reg(2'd2, 16'h0002);
    wr_reg(2'd3, 16'hBEA5);
    check_regs("R7");

    // system pair: push, push across zero, pop back
    op(0, "R3");
    op(0, "R5");
    op(1, "R4");
    check_regs("R5 R6");

    // R2: flag 0 selects user pair
    flag_wr_en = 1; flag_wr_val = 0;
    tick();
    check_regs("R2");
    op(0, "R2");
    op(1, "R4");
    check_regs("R6");

    // R8: flag write applies to a push in the same cycle
    flag_wr_en = 1; flag_wr_val = 1;
    op(0, "R8");
    check_regs("R8");

    // R9: interrupt overrides a flag write of 0 and steers the push
    flag_wr_en = 1; flag_wr_val = 0;
    tick();
    int_accept = 1; flag_wr_en = 1; flag_wr_val = 0;
    op(0, "R9");
    check_regs("R9");

    // R10: pointer write and push on the same pointer
    reg_wr_en = 1; reg_wr_sel = 2'd2; reg_wr_data = 16'h4000;
    op(0, "R10");
    check_regs("R10");
    // write to the other pointer while the system pair pushes
    reg_wr_en = 1; reg_wr_sel = 2'd0; reg_wr_data = 16'h2222;
    op(0, "R6");
    check_regs("R6");

    // R11: stall with addr_ready low
    repeat (3) @(negedge clk);
    addr_ready = 0;
    op(0, "R11");
    chk("R11 valid after accept", {31'h0, addr_valid}, 1);
    chk("R11 address after accept", addr_data, exp_q[0]);
    req_valid = 1; req_pop = 0;
    #2;
    chk("R11 ready low in stall", {31'h0, req_ready}, 0);
    @(negedge clk);
    req_valid = 0;
    chk("R11 address held", addr_data, exp_q[0]);
    chk("R11 valid held", {31'h0, addr_valid}, 1);
    addr_ready = 1;
    repeat (3) @(negedge clk);
    check_regs("R11");
    chk("R11 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule